// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a synchronous host and a 2K x 8 asynchronous static RAM whose chip enable, output enable and write enable are active low. The host hands over one transfer at a time: an 11-bit byte address, a read/write flag and, for writes, a data byte. The sequencer then runs one complete memory cycle. It drives the address, times the strobes in whole clock periods, drives the data bus for writes, and captures the byte that comes back on reads.

The number of clocks spent in each part of a cycle is set by parameters: the read access window, the width of the write pulse and the recovery gap that follows every cycle. The data bus is split into an outgoing value, a drive-enable and an incoming value, so a pad cell or an on-chip model can be attached. A write holds chip enable low for one setup clock before write enable falls. Both strobes then rise on the same edge, so the write cycle sits exactly inside the window where both are low. Output enable never moves during a write.

The host raises `req_valid` for one clock while the sequencer is idle. Idle means after reset, or in the clock where `ack` is high. The host then waits for `ack`, which marks the end of the whole cycle, recovery gap included.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is applied and in the first clock after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` and `ack` are 0, and `mem_addr` and `rd_data` are 0.
- R2: A request is taken only when the sequencer is idle. A `req_valid` seen during a running cycle starts no cycle, leaves `mem_addr` unchanged and writes nothing to memory.
- R3: A read taken at a clock edge holds `mem_ce_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for exactly ACC_CYC clocks, starting in the next clock.
- R4: `rd_data` takes the value of `mem_dq_in` from the last access clock of a read, on the edge that ends it. On that same edge `mem_ce_n` and `mem_oe_n` both return to 1. `rd_data` keeps its value until the next read completes.
- R5: A write taken at an edge gives one clock with `mem_ce_n`=0 and `mem_we_n`=1, then WP_CYC clocks with both at 0. Both then rise on the same edge. `mem_oe_n` stays 1 for the whole write.
- R6: `mem_dq_oe` is 1 exactly in the clocks where `mem_we_n` is 0. In those clocks `mem_dq_out` equals the requested write byte.
- R7: In every clock where `mem_oe_n` is 0, `mem_dq_oe` was 0 in the clock before.
- R8: `mem_addr` takes the request address on the edge that accepts it. It does not change until the next request is accepted.
- R9: After the strobes rise at the end of any cycle, all three stay at 1 for REC_CYC clocks. `ack` is then high for the next clock, so no new cycle starts within REC_CYC+1 clocks of the strobes rising.
- R10: `ack` is high for exactly one clock per accepted request, with all strobes at 1. A request presented in that clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to write |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Byte captured by the last read |
| mem_addr | output | ADDR_W | Address lines to the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data value driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Data value seen on the RAM bus |

## Verification
A phase register that is wrong, or a clock counter that is off by one, shows up as a strobe held one clock too long or too short. It appears in the first clock in which the cycle should have moved on. The reference model compares all strobes and `ack` every clock, so such a fault is caught within that clock. A wrong address or data register can leave the strobes correct and only corrupt the stored byte. That fault shows on `rd_data` when the byte is read back, which is why every address written is later read. A missed turnaround shows in the single clock where output enable falls.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_WR_SET,
        PH_WR_PULSE,
        PH_RECOV
    } phase_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one phase; expired is high once the count is zero.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = load_val;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign expired = (t_q.cnt == '0);

endmodule

// File: rtl/sram_bus_regs.sv
// Address, write-data and read-capture registers of the memory bus.
module sram_bus_regs #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (take_req) begin
            r_d.addr  = req_addr;
            r_d.wdata = req_wdata;
        end
        if (capture) begin
            r_d.rdata = bus_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.wdata;
    assign rd_data   = r_q.rdata;

endmodule

// File: rtl/sram_seq_ctrl.sv
// Top: sequences read and write cycles on an asynchronous static RAM.
module sram_seq_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 3,
    parameter int WP_CYC  = 2,
    parameter int REC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned MAX_CYC = max3(ACC_CYC, WP_CYC, REC_CYC);
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    typedef struct packed {
        phase_e phase;
        logic   ce_n;
        logic   oe_n;
        logic   we_n;
        logic   dq_oe;
        logic   ack;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_IDLE, ce_n: 1'b1, oe_n: 1'b1,
                                 we_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};

    seq_t s_d, s_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             take_req;
    logic             capture;

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_done)
    );

    sram_bus_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_req (take_req),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .capture  (capture),
        .bus_in   (mem_dq_in),
        .bus_addr (mem_addr),
        .bus_wdata(mem_dq_out),
        .rd_data  (rd_data)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take_req = 1'b0;
        capture  = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    s_d.ce_n = 1'b0;
                    if (req_write) begin
                        s_d.phase = PH_WR_SET;
                    end else begin
                        s_d.phase = PH_RD_ACC;
                        s_d.oe_n  = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = ACC_LD;
                    end
                end
            end
            PH_RD_ACC: begin
                if (tmr_done) begin
                    capture   = 1'b1;
                    s_d.ce_n  = 1'b1;
                    s_d.oe_n  = 1'b1;
                    s_d.phase = PH_RECOV;
                    tmr_load  = 1'b1;
                    tmr_val   = REC_LD;
                end
            end
            PH_WR_SET: begin
                s_d.we_n  = 1'b0;
                s_d.dq_oe = 1'b1;
                s_d.phase = PH_WR_PULSE;
                tmr_load  = 1'b1;
                tmr_val   = WP_LD;
            end
            PH_WR_PULSE: begin
                if (tmr_done) begin
                    s_d.we_n  = 1'b1;
                    s_d.ce_n  = 1'b1;
                    s_d.dq_oe = 1'b0;
                    s_d.phase = PH_RECOV;
                    tmr_load  = 1'b1;
                    tmr_val   = REC_LD;
                end
            end
            PH_RECOV: begin
                if (tmr_done) begin
                    s_d.phase = PH_IDLE;
                    s_d.ack   = 1'b1;
                end
            end
            default: begin
                s_d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack       = s_q.ack;
    assign mem_ce_n  = s_q.ce_n;
    assign mem_oe_n  = s_q.oe_n;
    assign mem_we_n  = s_q.we_n;
    assign mem_dq_oe = s_q.dq_oe;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
// Protocol checker for the memory side of sram_seq_ctrl.
module sram_seq_ctrl_chk #(
    parameter int ADDR_W  = 11,
    parameter int WP_CYC  = 2,
    parameter int REC_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    logic [15:0] we_low_q;
    logic [15:0] ce_high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q  <= '0;
            ce_high_q <= 16'(REC_CYC + 1);
        end else begin
            if (!mem_we_n) begin
                if (we_low_q != 16'hFFFF) we_low_q <= we_low_q + 16'd1;
            end else begin
                we_low_q <= '0;
            end
            if (mem_ce_n) begin
                if (ce_high_q != 16'hFFFF) ce_high_q <= ce_high_q + 16'd1;
            end else begin
                ce_high_q <= '0;
            end
        end
    end

    p_oe_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    p_ce_oe_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> $rose(mem_ce_n));

    p_oe_quiet_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_q == 16'(WP_CYC)));

    p_ce_we_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ce_n));

    p_drive_needs_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    p_we_needs_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (ce_high_q >= 16'(REC_CYC + 1)));

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (mem_ce_n && mem_oe_n && mem_we_n));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sram_seq_ctrl;

    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int ACC = 3;
    localparam int WP  = 2;
    localparam int REC = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    always #2 clk = ~clk;

    sram_seq_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .WP_CYC(WP), .REC_CYC(REC)
    ) i_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Behavioural RAM on the memory side.
    logic [DW-1:0] sram [DEPTH];
    initial for (int i = 0; i < DEPTH; i++) sram[i] = '0;
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) sram[mem_addr] <= mem_dq_out;
    end
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? sram[mem_addr] : '0;

    // Reference model: a queue of expected per-clock port values.
    typedef struct {
        bit            ce_n, oe_n, we_n, dq_oe, ack;
        logic [AW-1:0] addr;
        logic [DW-1:0] rd, wd;
        string         tag;
    } exp_t;

    exp_t          q[$];
    exp_t          e;
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_rd = '0;
    bit            acc_flag = 1'b0;
    bit            refused = 1'b0;
    bit            prev_dq = 1'b0;
    int            n_checks = 0;
    int            n_err = 0;

    initial for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic void push(input bit ce, input bit oe, input bit we, input bit dq,
                                 input bit ak, input logic [DW-1:0] wd, input string tag);
        exp_t x;
        x.ce_n = ce; x.oe_n = oe; x.we_n = we; x.dq_oe = dq; x.ack = ak;
        x.addr = last_addr; x.rd = last_rd; x.wd = wd; x.tag = tag;
        q.push_back(x);
    endfunction

    function automatic void plan_cycle(input bit w, input logic [AW-1:0] a,
                                       input logic [DW-1:0] d);
        last_addr = a;
        if (w) begin
            ref_mem[a] = d;
            push(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, d, "R5");
            for (int i = 0; i < WP; i++) push(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, d, "R5");
        end else begin
            for (int i = 0; i < ACC; i++) push(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, d, "R3");
            last_rd = ref_mem[a];
        end
        for (int i = 0; i < REC; i++) push(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, d, "R9");
        push(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, d, "R10");
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            // R1: reset state
            chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack} == 5'b11100, "R1",
                "strobes in reset", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}),
                32'h1C);
            prev_dq  = 1'b0;
            acc_flag = 1'b0;
        end else begin
            if (q.size() > 0) begin
                e = q.pop_front();
            end else begin
                e.ce_n = 1'b1; e.oe_n = 1'b1; e.we_n = 1'b1; e.dq_oe = 1'b0; e.ack = 1'b0;
                e.addr = last_addr; e.rd = last_rd; e.wd = '0; e.tag = "R10";
            end
            chk({mem_ce_n, mem_oe_n, mem_we_n, ack} == {e.ce_n, e.oe_n, e.we_n, e.ack},
                e.tag, "ce/oe/we/ack", 32'({mem_ce_n, mem_oe_n, mem_we_n, ack}),
                32'({e.ce_n, e.oe_n, e.we_n, e.ack}));
            chk(mem_dq_oe == e.dq_oe, "R6", "dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe));
            if (e.dq_oe) chk(mem_dq_out == e.wd, "R6", "dq_out", 32'(mem_dq_out), 32'(e.wd));
            chk(mem_addr == e.addr, refused ? "R2" : "R8", "mem_addr",
                32'(mem_addr), 32'(e.addr));
            chk(rd_data == e.rd, "R4", "rd_data", 32'(rd_data), 32'(e.rd));
            if (!mem_oe_n) chk(!prev_dq, "R7", "dq_oe before oe", 32'(prev_dq), 32'h0);
            prev_dq  = mem_dq_oe;
            acc_flag = 1'b0;
            refused  = 1'b0;
            if (req_valid) begin
                if (q.size() == 0) begin
                    acc_flag = 1'b1;
                    plan_cycle(req_write, req_addr, req_wdata);
                end else begin
                    refused = 1'b1;
                end
            end
        end
    end

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        do @(posedge clk); while (!acc_flag);
        #1;
        req_valid = 1'b0; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
    endtask

    // R2: a write request held while a cycle is running must be dropped.
    task automatic poke_busy(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        repeat (2) @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog: got %0d completed expected all", 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        repeat (2) @(posedge clk);
        #1;
        issue(1'b1, 11'h000, 8'h5A);
        issue(1'b1, 11'h7FF, 8'hFF);
        issue(1'b1, 11'h123, 8'h3C);
        poke_busy(11'h123, 8'hEE);
        issue(1'b0, 11'h000, 8'h00);   // R7 read right after a write
        issue(1'b0, 11'h7FF, 8'h00);
        issue(1'b0, 11'h123, 8'h00);   // R2 poked byte must still be 3C
        repeat (3) @(posedge clk);
        #1;
        issue(1'b0, 11'h456, 8'h00);   // never written: 00
        issue(1'b1, 11'h456, 8'hA5);
        poke_busy(11'h000, 8'h11);
        issue(1'b0, 11'h456, 8'h00);
        issue(1'b0, 11'h000, 8'h00);
        for (int i = 0; i < 8; i++) issue(1'b1, 11'((i * 257) & 11'h7FF), 8'(i * 17 + 1));
        for (int i = 7; i >= 0; i--) issue(1'b0, 11'((i * 257) & 11'h7FF), 8'h00);
        repeat (REC + 6) @(posedge clk);
        finish_run();
    end

endmodule